// File: doc/BRIEF.md
# Radio Link Loss Watchdog

This block decides whether the radio link behind a hobby receiver is still alive. It does this by watching pulse activity on the receiver's output channels. A separate pulse timer measures the channel pulse widths. Each time that timer completes a pulse on a channel, it raises a sticky new-pulse request for that channel. The watchdog takes the request, acknowledges it for one cycle, and restarts that channel's private millisecond timer. A one-cycle millisecond strobe from the system drives a free-running 16-bit millisecond count. The watchdog compares each channel's time since its last restart against a timeout limit, and keeps a sticky timed-out flag for each channel.

A single link-fail output combines the timed-out flags of a configurable set of critical channels. By default the critical set is the first two receiver channels, which are bits 0 and 1 of the channel vectors. Flags on the other channels are left out on purpose. Some receivers keep emitting slow pulses on those channels after the link is gone, so pulses there must never hold off the fail indication. After reset every channel counts as timed out, so the fail output stays high until the critical channels have shown pulses.

Top module: `rcw_link_watchdog`

## Requirements
- R1: After reset, every bit of `chan_timeout` is 1, `tx_fail` is 1 and every bit of `pulse_ack` is 0.
- R2: If `pulse_new[i]` is high in a cycle where `pulse_ack[i]` is low, the request is taken. In the next cycle `pulse_ack[i]` is 1 and `chan_timeout[i]` is 0.
- R3: `pulse_ack[i]` never stays high for two cycles in a row. A request still held high during the cycle its acknowledge shows is not taken again in that cycle.
- R4: A channel keeps a stamp of the millisecond count at its last accepted request. In every cycle without a request it compares the count minus the stamp against TIMEOUT_MS. When the difference is strictly greater, `chan_timeout[i]` becomes 1 on the next edge. A strobe arriving in the same cycle as a request already counts toward the new interval.
- R5: The millisecond count is 16 bits wide and the difference is taken modulo 65536. A channel restarted just before the count wraps times out after the same number of strobes as anywhere else.
- R6: Once `chan_timeout[i]` is 1, it stays 1 whatever strobes arrive, until a new request is taken on that channel.
- R7: `tx_fail` is 1 exactly when a channel selected by CRIT_MASK has its timed-out flag set. CRIT_MASK bit i selects channel i, and the default value 0b11 selects channels 0 and 1. Flags and pulses on unselected channels have no effect on `tx_fail`.
- R8: A request taken on one channel leaves the timed-out flag of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| pulse_new | input | NCH | Sticky new-pulse request for each channel, from the pulse timer |
| pulse_ack | output | NCH | One-cycle acknowledge for each channel; the pulse timer clears its request on it |
| chan_timeout | output | NCH | Sticky timed-out flag for each channel |
| tx_fail | output | 1 | Link-loss indication, built from the critical channels |

## Verification
A wrong stamp or a miscounted millisecond shows up at `chan_timeout` as a flag that rises one or more strobes too early or too late. The first interval after a restart reveals it within TIMEOUT_MS+1 strobes. A difference that does not wrap properly makes a flag fire at once or never, and only a restart placed just before the 16-bit wrap exposes it. A wrong mask or a wrong merge shows in the same cycle as a difference between `tx_fail` and the critical flags. A broken acknowledge shows within one cycle as a doubled or missing `pulse_ack`.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
  localparam int unsigned MS_W = 16;
  typedef logic [MS_W-1:0] ms_t;

  // Milliseconds since a mark, modulo 2^MS_W so counter wrap is harmless.
  function automatic ms_t ms_since(input ms_t now, input ms_t mark);
    return ms_t'(now - mark);
  endfunction

  // Strictly-greater comparison against the limit.
  function automatic logic past_limit(input ms_t elapsed, input ms_t limit);
    return elapsed > limit;
  endfunction
endpackage

// File: rtl/rcw_ms_clock.sv
module rcw_ms_clock
  import rcw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  output ms_t  now_ms
);
  ms_t cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (ms_tick) cnt_q <= cnt_q + ms_t'(1);
  end

  assign now_ms = cnt_q;
endmodule

// File: rtl/rcw_chan_dog.sv
module rcw_chan_dog
  import rcw_pkg::*;
#(
  parameter int TIMEOUT_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  ms_t  now_ms,
  input  logic pulse_new,
  output logic pulse_ack,
  output logic timed_out,
  output logic kick_evt,
  output logic expire_evt
);
  localparam ms_t LIMIT = ms_t'(TIMEOUT_MS);

  ms_t  stamp_q;
  logic ack_q;
  logic to_q;
  logic over;

  assign kick_evt   = pulse_new && !ack_q;
  assign over       = past_limit(ms_since(now_ms, stamp_q), LIMIT);
  assign expire_evt = !kick_evt && over;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp_q <= '0;
      ack_q   <= 1'b0;
      to_q    <= 1'b1;
    end else begin
      ack_q <= kick_evt;
      if (kick_evt) begin
        stamp_q <= now_ms;
        to_q    <= 1'b0;
      end else if (expire_evt) begin
        to_q <= 1'b1;
      end
    end
  end

  assign pulse_ack = ack_q;
  assign timed_out = to_q;
endmodule

// File: rtl/rcw_fail_merge.sv
module rcw_fail_merge #(
  parameter int            NCH       = 8,
  parameter logic [NCH-1:0] CRIT_MASK = NCH'(2'b11)
) (
  input  logic [NCH-1:0] timed_out,
  output logic           fail
);
  logic [NCH-1:0] sel;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    if (CRIT_MASK[i]) begin : g_crit
      assign sel[i] = timed_out[i];
    end else begin : g_skip
      assign sel[i] = 1'b0;
    end
  end

  assign fail = |sel;
endmodule

// File: rtl/rcw_link_watchdog.sv
module rcw_link_watchdog
  import rcw_pkg::*;
#(
  parameter int             NCH        = 8,
  parameter int             TIMEOUT_MS = 100,
  parameter logic [NCH-1:0] CRIT_MASK  = NCH'(2'b11)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ms_tick,
  input  logic [NCH-1:0] pulse_new,
  output logic [NCH-1:0] pulse_ack,
  output logic [NCH-1:0] chan_timeout,
  output logic           tx_fail
);
  ms_t            now_ms;
  logic [NCH-1:0] kick_evt;
  logic [NCH-1:0] expire_evt;

  rcw_ms_clock u_clock (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick),
    .now_ms  (now_ms)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    rcw_chan_dog #(.TIMEOUT_MS(TIMEOUT_MS)) u_dog (
      .clk        (clk),
      .rst_n      (rst_n),
      .now_ms     (now_ms),
      .pulse_new  (pulse_new[i]),
      .pulse_ack  (pulse_ack[i]),
      .timed_out  (chan_timeout[i]),
      .kick_evt   (kick_evt[i]),
      .expire_evt (expire_evt[i])
    );
  end

  rcw_fail_merge #(.NCH(NCH), .CRIT_MASK(CRIT_MASK)) u_merge (
    .timed_out (chan_timeout),
    .fail      (tx_fail)
  );
endmodule

// File: rtl/rcw_link_watchdog_chk.sv
module rcw_link_watchdog_chk #(
  parameter int             NCH       = 8,
  parameter logic [NCH-1:0] CRIT_MASK = NCH'(2'b11)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] pulse_new,
  input logic [NCH-1:0] pulse_ack,
  input logic [NCH-1:0] chan_timeout,
  input logic           tx_fail,
  input logic [NCH-1:0] kick_evt,
  input logic [NCH-1:0] expire_evt
);
  for (genvar i = 0; i < NCH; i++) begin : g_p
    // R3: acknowledge is a single-cycle pulse
    p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_ack[i] |=> !pulse_ack[i]);
    // R2: an acknowledge follows a request and shows a cleared flag
    p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      kick_evt[i] |=> (pulse_ack[i] && !chan_timeout[i]));
    p_ack_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_new[i] && pulse_ack[i] |-> !kick_evt[i]);
    // R4: a flag only rises after the limit check fired
    p_rise_on_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      expire_evt[i] |=> chan_timeout[i]);
    // R6: a set flag holds until a request is taken
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chan_timeout[i] && !kick_evt[i] |=> chan_timeout[i]);
  end

  // R7: fail can only drop when a critical channel was restarted
  p_fail_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail && ((kick_evt & CRIT_MASK) == '0) |=> tx_fail);
  // R7: fail can only rise when a critical channel expired
  p_fail_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_fail && ((expire_evt & CRIT_MASK) == '0) |=> !tx_fail);
endmodule

bind rcw_link_watchdog rcw_link_watchdog_chk #(.NCH(NCH), .CRIT_MASK(CRIT_MASK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pulse_new    (pulse_new),
  .pulse_ack    (pulse_ack),
  .chan_timeout (chan_timeout),
  .tx_fail      (tx_fail),
  .kick_evt     (kick_evt),
  .expire_evt   (expire_evt)
);

// File: tb/rcw_link_watchdog_tb_top.sv
module rcw_link_watchdog_tb_top;
  localparam int NCH = 4;
  localparam int TMO = 5;
  localparam logic [NCH-1:0] MASK = 4'b0011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic [NCH-1:0] pulse_new = '0;
  logic [NCH-1:0] pulse_ack;
  logic [NCH-1:0] chan_timeout;
  logic tx_fail;

  always #5 clk = ~clk;

  rcw_link_watchdog #(.NCH(NCH), .TIMEOUT_MS(TMO), .CRIT_MASK(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pulse_new(pulse_new),
    .pulse_ack(pulse_ack), .chan_timeout(chan_timeout), .tx_fail(tx_fail)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference
  int m_now = 0;
  int m_stamp [NCH];
  bit m_to [NCH];
  bit m_ack [NCH];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic model_reset();
    m_now = 0;
    for (int i = 0; i < NCH; i++) begin
      m_stamp[i] = 0; m_to[i] = 1; m_ack[i] = 0;
    end
  endtask

  task automatic step(input logic tick, input logic [NCH-1:0] pn);
    bit nack [NCH];
    int elapsed;
    int fail_exp;
    @(negedge clk);
    ms_tick = tick;
    pulse_new = pn;
    @(posedge clk);
    for (int i = 0; i < NCH; i++) begin
      nack[i] = pn[i] && !m_ack[i];
      elapsed = (m_now - m_stamp[i] + 65536) % 65536;
      if (nack[i]) begin
        m_stamp[i] = m_now; m_to[i] = 0;
      end else if (elapsed > TMO) begin
        m_to[i] = 1;
      end
    end
    for (int i = 0; i < NCH; i++) m_ack[i] = nack[i];
    if (tick) m_now = (m_now + 1) % 65536;
    #1;
    fail_exp = 0;
    for (int i = 0; i < NCH; i++) begin
      if (MASK[i] && m_to[i]) fail_exp = 1;
      check($sformatf("R2/R3 ack ch%0d", i), int'(pulse_ack[i]), int'(m_ack[i]));
      check($sformatf("R4 timeout ch%0d", i), int'(chan_timeout[i]), int'(m_to[i]));
    end
    check("R7 tx_fail", int'(tx_fail), fail_exp);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : stim
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 timeouts", int'(chan_timeout), 15);
    check("R1 tx_fail", int'(tx_fail), 1);
    check("R1 ack", int'(pulse_ack), 0);

    // kick critical channels
    step(0, 4'b0011);
    check("R2 ch0 cleared", int'(chan_timeout[0]), 0);
    check("R8 ch2 untouched", int'(chan_timeout[2]), 1);
    check("R7 fail low", int'(tx_fail), 0);
    step(0, 4'b0000);

    // ch0 kept alive, ch1 starves: fail must rise
    for (int k = 0; k < 30; k++) begin
      step((k % 3) == 0, ((k % 5) == 0) ? 4'b0001 : 4'b0000);
    end
    check("R7 fail from ch1", int'(tx_fail), 1);

    // held request: acks on alternate cycles
    step(0, 4'b0100);
    step(0, 4'b0100);
    check("R3 no second ack", int'(pulse_ack[2]), 0);
    step(0, 4'b0100);
    step(0, 4'b0000);

    // critical alive, non-critical ch3 timed out
    step(0, 4'b0011);
    step(0, 4'b0000);
    check("R7 ch3 ignored", int'(tx_fail), 0);
    check("R7 ch3 still out", int'(chan_timeout[3]), 1);
    // non-critical pulses cannot clear fail
    for (int k = 0; k < 8; k++) step(1, 4'b0000);
    for (int k = 0; k < 6; k++) step(0, (k % 2) ? 4'b0000 : 4'b1100);
    check("R7 fail held despite ch2/ch3", int'(tx_fail), 1);

    // stickiness
    for (int k = 0; k < 100; k++) step(1, 4'b0000);
    check("R6 ch1 sticky", int'(chan_timeout[1]), 1);

    // wrap: run count up to 65533
    while (m_now != 65533) step(1, 4'b0000);
    step(1, 4'b0010);
    for (int k = 0; k < 5; k++) step(1, 4'b0000);
    check("R5 before limit across wrap", int'(chan_timeout[1]), 0);
    step(1, 4'b0000);
    check("R5 at limit across wrap", int'(chan_timeout[1]), 1);
    for (int k = 0; k < 4; k++) step(0, 4'b0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule